// File: doc/BRIEF.md
# Drift Chamber Track Coincidence Discriminator

This block sorts the azimuthal sectors of a drift chamber into long-track, short-track and empty sectors for a first-level trigger. Its inputs are four track-segment bitmaps, one for each axial superlayer: outer, middle, inner-upper and inner-lower. Segment finding upstream has already mapped every bitmap onto a common grid of 32 sectors. For each sector the block tests a road centred on that sector. The road takes a segment found in the same sector or in either neighbour, and sector 0 and sector 31 count as neighbours.

A long track is anchored on the outer superlayer. It is a majority vote over four superlayers, and a runtime select sets how many votes it needs: three or four. A short track is anchored on the middle superlayer and needs segments in all three of the inner superlayers. A sector that qualifies as long is never reported as short. In the three-of-four mode every short candidate already has three votes, so it is reported as long. Short tracks can therefore appear only in the four-of-four mode. Every clock the block registers a long flag and a short flag for each sector, together with a saturating count of each kind, for the global trigger logic downstream.

Top module: `trk_coincidence`

## Requirements
- R1: The road for sector s takes an inner or middle superlayer segment found in sector s, (s+31) mod 32 or (s+1) mod 32. Bit i of every bitmap is sector i. The outer superlayer is read only at sector s.
- R2: With strictLong=0, longFlags[s] is 1 when at least 3 of these 4 votes hold: outerSeg[s], the road on middleSeg, the road on innerUpSeg, the road on innerLowSeg.
- R3: shortFlags[s] is 1 when middleSeg[s] is set, the road on innerUpSeg holds and the road on innerLowSeg holds, unless the sector is long.
- R4: With strictLong=1, longFlags[s] needs all 4 votes.
- R5: No sector is flagged long and short in the same cycle.
- R6: longCount and shortCount equal the number of set bits in longFlags and shortFlags, saturating at 15.
- R7: All outputs are registered. They reflect the inputs present at the previous rising clock edge, and they are 0 while rstN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rstN | input | 1 | Active-low reset |
| strictLong | input | 1 | 0: long track needs 3 of 4 votes; 1: needs 4 of 4 |
| outerSeg | input | 32 | Outer superlayer segment bitmap (long reference) |
| middleSeg | input | 32 | Middle superlayer bitmap (short reference) |
| innerUpSeg | input | 32 | Upper inner superlayer bitmap |
| innerLowSeg | input | 32 | Lower inner superlayer bitmap |
| longFlags | output | 32 | Per-sector long track flags |
| shortFlags | output | 32 | Per-sector short track flags |
| longCount | output | 4 | Saturating number of long sectors |
| shortCount | output | 4 | Saturating number of short sectors |

## Verification
The assertions assume that every input, strictLong included, is stable and known at each rising edge, so the previous-cycle values they sample stand for one valid set of bitmaps. The bench changes inputs only on falling edges and never drives X. The stimulus covers wrap-around at sector 0 and sector 31, both vote modes, and full bitmaps that push each count past 15. Random bitmaps of several densities are mixed in, and strictLong changes from one cycle to the next.

// File: rtl/trkcoin_pkg.sv
package trkcoin_pkg;
  typedef struct packed {
    logic allowThree;
    logic requireFour;
  } voteStrobes_t;
endpackage

// File: rtl/trkcoin_ctrl.sv
module trkcoin_ctrl
  import trkcoin_pkg::*;
(
  input  logic         strictLong,
  output voteStrobes_t strobes
);
  always_comb begin
    strobes.requireFour = strictLong;
    strobes.allowThree  = ~strictLong;
  end
endmodule

// File: rtl/trkcoin_datapath.sv
module trkcoin_datapath
  import trkcoin_pkg::*;
#(
  parameter int NUM_SECTORS = 32,
  parameter int COUNT_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  voteStrobes_t           strobes,
  input  logic [NUM_SECTORS-1:0] outerSeg,
  input  logic [NUM_SECTORS-1:0] middleSeg,
  input  logic [NUM_SECTORS-1:0] innerUpSeg,
  input  logic [NUM_SECTORS-1:0] innerLowSeg,
  output logic [NUM_SECTORS-1:0] longFlags,
  output logic [NUM_SECTORS-1:0] shortFlags,
  output logic [COUNT_W-1:0]     longCount,
  output logic [COUNT_W-1:0]     shortCount
);
  localparam int POP_W = $clog2(NUM_SECTORS + 1);
  localparam int SAT   = (1 << COUNT_W) - 1;

  logic [NUM_SECTORS-1:0] roadMid, roadUp, roadLow;
  logic [NUM_SECTORS-1:0] longNext, shortNext;
  logic [POP_W-1:0]       longPop, shortPop;
  logic [COUNT_W-1:0]     longSat, shortSat;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    localparam int LO = (s + NUM_SECTORS - 1) % NUM_SECTORS;
    localparam int HI = (s + 1) % NUM_SECTORS;
    logic [2:0] votes;

    assign roadMid[s] = middleSeg[LO]   | middleSeg[s]   | middleSeg[HI];
    assign roadUp[s]  = innerUpSeg[LO]  | innerUpSeg[s]  | innerUpSeg[HI];
    assign roadLow[s] = innerLowSeg[LO] | innerLowSeg[s] | innerLowSeg[HI];
    assign votes = {2'b00, outerSeg[s]} + {2'b00, roadMid[s]}
                 + {2'b00, roadUp[s]}   + {2'b00, roadLow[s]};
    assign longNext[s] = strobes.requireFour ? (votes == 3'd4)
                                             : (strobes.allowThree && votes >= 3'd3);
    assign shortNext[s] = middleSeg[s] & roadUp[s] & roadLow[s] & ~longNext[s];

    p_strict_ref_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strobes.requireFour) && longFlags[s]) |-> $past(outerSeg[s]))
      else $error("strict long flag without outer reference");
    p_short_ref_r3: assert property (@(posedge clk) disable iff (!rstN)
      shortFlags[s] |-> $past(middleSeg[s]))
      else $error("short flag without middle reference");
  end

  always_comb begin
    longPop  = '0;
    shortPop = '0;
    for (int i = 0; i < NUM_SECTORS; i++) begin
      longPop  = longPop  + POP_W'(longNext[i]);
      shortPop = shortPop + POP_W'(shortNext[i]);
    end
    longSat  = (longPop  > POP_W'(SAT)) ? COUNT_W'(SAT) : COUNT_W'(longPop);
    shortSat = (shortPop > POP_W'(SAT)) ? COUNT_W'(SAT) : COUNT_W'(shortPop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      longFlags  <= '0;
      shortFlags <= '0;
      longCount  <= '0;
      shortCount <= '0;
    end else begin
      longFlags  <= longNext;
      shortFlags <= shortNext;
      longCount  <= longSat;
      shortCount <= shortSat;
    end
  end

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (longFlags & shortFlags) == '0)
    else $error("sector flagged long and short");
  p_long_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    longCount == (($countones(longFlags) > SAT) ? COUNT_W'(SAT)
                                                : COUNT_W'($countones(longFlags))))
    else $error("long count disagrees with flags");
  p_short_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    shortCount == (($countones(shortFlags) > SAT) ? COUNT_W'(SAT)
                                                  : COUNT_W'($countones(shortFlags))))
    else $error("short count disagrees with flags");
endmodule

// File: rtl/trk_coincidence.sv
module trk_coincidence
  import trkcoin_pkg::*;
#(
  parameter int NUM_SECTORS = 32,
  parameter int COUNT_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   strictLong,
  input  logic [NUM_SECTORS-1:0] outerSeg,
  input  logic [NUM_SECTORS-1:0] middleSeg,
  input  logic [NUM_SECTORS-1:0] innerUpSeg,
  input  logic [NUM_SECTORS-1:0] innerLowSeg,
  output logic [NUM_SECTORS-1:0] longFlags,
  output logic [NUM_SECTORS-1:0] shortFlags,
  output logic [COUNT_W-1:0]     longCount,
  output logic [COUNT_W-1:0]     shortCount
);
  voteStrobes_t strobes;

  trkcoin_ctrl u_ctrl (
    .strictLong (strictLong),
    .strobes    (strobes)
  );

  trkcoin_datapath #(
    .NUM_SECTORS (NUM_SECTORS),
    .COUNT_W     (COUNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .outerSeg    (outerSeg),
    .middleSeg   (middleSeg),
    .innerUpSeg  (innerUpSeg),
    .innerLowSeg (innerLowSeg),
    .longFlags   (longFlags),
    .shortFlags  (shortFlags),
    .longCount   (longCount),
    .shortCount  (shortCount)
  );
endmodule

// File: tb/tb_trk_coincidence.sv
module tb_trk_coincidence;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strictLong = 1'b0;
  logic [31:0] outerSeg = '0, middleSeg = '0, innerUpSeg = '0, innerLowSeg = '0;
  logic [31:0] longFlags, shortFlags;
  logic [3:0]  longCount, shortCount;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [31:0] expLong, expShort;
  int          expLc, expSc;

  always #2 clk = ~clk;

  trk_coincidence dut (
    .clk(clk), .rstN(rstN), .strictLong(strictLong),
    .outerSeg(outerSeg), .middleSeg(middleSeg),
    .innerUpSeg(innerUpSeg), .innerLowSeg(innerLowSeg),
    .longFlags(longFlags), .shortFlags(shortFlags),
    .longCount(longCount), .shortCount(shortCount)
  );

  function automatic bit road(input logic [31:0] v, input int s);
    return v[(s + 31) % 32] || v[s] || v[(s + 1) % 32];
  endfunction

  task automatic model();
    int n = 0, m = 0;
    expLong = '0;
    expShort = '0;
    for (int s = 0; s < 32; s++) begin
      int v = 0;
      bit isLong;
      if (outerSeg[s]) v++;
      if (road(middleSeg, s)) v++;
      if (road(innerUpSeg, s)) v++;
      if (road(innerLowSeg, s)) v++;
      isLong = strictLong ? (v == 4) : (v >= 3);
      expLong[s] = isLong;
      expShort[s] = !isLong && middleSeg[s] && road(innerUpSeg, s) && road(innerLowSeg, s);
      if (expLong[s]) n++;
      if (expShort[s]) m++;
    end
    expLc = (n > 15) ? 15 : n;
    expSc = (m > 15) ? 15 : m;
  endtask

  task automatic checkVal(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    checkVal({tag, " R2/R4 longFlags"}, longFlags, expLong);
    checkVal({tag, " R3 R5 shortFlags"}, shortFlags, expShort);
    checkVal({tag, " R6 longCount"}, longCount, expLc);
    checkVal({tag, " R6 shortCount"}, shortCount, expSc);
  endtask

  task automatic apply(input string tag, input bit st, input logic [31:0] o,
                       input logic [31:0] m, input logic [31:0] u, input logic [31:0] l);
    strictLong = st; outerSeg = o; middleSeg = m; innerUpSeg = u; innerLowSeg = l;
    model();
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    outerSeg = '1; middleSeg = '1; innerUpSeg = '1; innerLowSeg = '1;
    @(negedge clk);
    checkVal("R7 reset longFlags", longFlags, 0);
    checkVal("R7 reset shortFlags", shortFlags, 0);
    checkVal("R7 reset longCount", longCount, 0);
    checkVal("R7 reset shortCount", shortCount, 0);
    rstN = 1'b1;
    apply("R7 idle", 1'b0, '0, '0, '0, '0);
    apply("R2 same sector", 1'b0, 32'h0000_0100, 32'h0000_0100, 32'h0000_0100, 32'h0);
    apply("R1 wrap low", 1'b0, 32'h0000_0001, 32'h8000_0000, 32'h0000_0002, 32'h8000_0000);
    apply("R1 wrap high", 1'b1, 32'h8000_0000, 32'h0000_0001, 32'h4000_0000, 32'h0000_0001);
    apply("R1 out of road", 1'b0, 32'h0000_0010, 32'h0000_0040, 32'h0000_0004, 32'h0);
    apply("R4 three only", 1'b1, 32'h0001_0000, 32'h0001_0000, 32'h0002_0000, 32'h0);
    apply("R3 short strict", 1'b1, 32'h0, 32'h0000_0800, 32'h0000_1000, 32'h0000_0400);
    apply("R5 short masked", 1'b0, 32'h0, 32'h0000_0800, 32'h0000_1000, 32'h0000_0400);
    apply("R6 long sat", 1'b0, '1, '1, '1, '1);
    apply("R6 short sat", 1'b1, '0, '1, '1, '1);
    for (int i = 0; i < 800; i++) begin
      logic [31:0] o, m, u, l;
      o = $urandom; m = $urandom; u = $urandom; l = $urandom;
      if (i % 3 == 0) begin
        o = o & $urandom & $urandom; m = m & $urandom;
        u = u & $urandom; l = l & $urandom;
      end else if (i % 3 == 1) begin
        o = o & $urandom & $urandom & $urandom; m = m & $urandom & $urandom;
        u = u & $urandom & $urandom; l = l & $urandom & $urandom;
      end
      apply("R1 random", 1'($urandom), o, m, u, l);
    end
    rstN = 1'b0;
    #1;
    checkVal("R7 async reset longFlags", longFlags, 0);
    checkVal("R7 async reset longCount", longCount, 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule